// File: doc/BRIEF.md
# Power-Up Sequencing Controller

This controller brings a chip's supplies and clocks up in a fixed order once the battery is present. It watches a brown-out-good input and the ready flags returned by the regulators and oscillators. It drives an enable for each of them and finally releases the power-on reset to the digital domain. The always-on and retention regulators are enabled from reset. Once brown-out is clear, a deglitch interval must elapse and both of those regulators must report ready. Only then are the low-frequency RC clock and the random-number oscillator started. The switching regulator and the RF linear regulator come next. After a stabilisation interval, the core regulator, the active I/O regulator, the crystal oscillator and the high-frequency RC oscillator are enabled together. The PLL enable stays low until the crystal reports stable.

Power-on reset is released when every basic regulator and clock reports ready. At the same moment an I/O droop flag is raised, which lowers the active I/O rail by about 100 mV as a visible sign of the release. In sleep the standby I/O regulator takes over and the active one is switched off. A mode input names the RF supply source, and the block clamps the requested TX power to the range that source allows. Each stage that waits on ready flags has a timeout that sets a sticky fault. Loss of brown-out-good sends the controller straight back to its reset state.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After rst_n, only aon_en and ret_en are high. Every other enable is low, por_n is 0 and fault is 0.
- R2: With all ready flags high, lfrc_en and rng_en rise exactly DGL_CYC+2 clock edges after the first edge that samples bor_ok high. They never rise before aon_rdy and ret_rdy have been sampled high.
- R3: buck_en and rfldo_en rise one edge after lfrc_rdy and rng_rdy are sampled high in the low-clock stage.
- R4: core_en, aio_en, xo_en and hfrc_en rise together STB_CYC+1 edges after buck_rdy and rfldo_rdy are first sampled high.
- R5: pll_en is low while xo_rdy is low. From the main stage onward it follows xo_rdy within the same cycle.
- R6: por_n rises one edge after core_rdy, aio_rdy, xo_rdy, hfrc_rdy and pll_rdy are all sampled high. aio_drop is high while awake with reset released.
- R7: Sampling sleep_req high while running sets sio_en=1, aio_en=0 and aio_drop=0 at the next edge, and por_n stays 1. Sampling sleep_req low restores aio_en=1, sio_en=0 and aio_drop=1.
- R8: txpwr_out equals txpwr_req (signed dBm) clamped to [-20, +6] when rf_src_ldo=0, and to [-20, +15] when rf_src_ldo=1.
- R9: If a wait stage's ready flags are still low on the TO_CYC-th edge in that stage, fault is set. It stays set until rst_n. A ready flag sampled on that same edge advances the stage and sets no fault.
- R10: Sampling bor_ok low returns the controller to its reset state at the next edge. Only aon_en and ret_en stay high. This takes priority over sleep_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| bor_ok | input | 1 | Brown-out-good, high when battery is above threshold |
| aon_rdy | input | 1 | Always-on regulator ready |
| ret_rdy | input | 1 | Retention regulator ready |
| lfrc_rdy | input | 1 | Low-frequency RC clock running |
| rng_rdy | input | 1 | Random-number oscillator running |
| buck_rdy | input | 1 | Switching regulator ready |
| rfldo_rdy | input | 1 | RF linear regulator ready |
| core_rdy | input | 1 | Core regulator ready |
| aio_rdy | input | 1 | Active I/O regulator ready |
| xo_rdy | input | 1 | Crystal oscillator stable |
| hfrc_rdy | input | 1 | High-frequency RC oscillator running |
| pll_rdy | input | 1 | PLL locked |
| sleep_req | input | 1 | Sleep request |
| rf_src_ldo | input | 1 | RF supply source: 0 switching, 1 linear |
| txpwr_req | input | 8 | Requested TX power, signed dBm |
| aon_en | output | 1 | Always-on regulator enable |
| ret_en | output | 1 | Retention regulator enable |
| lfrc_en | output | 1 | Low-frequency RC clock enable |
| rng_en | output | 1 | Random-number oscillator enable |
| buck_en | output | 1 | Switching regulator enable |
| rfldo_en | output | 1 | RF linear regulator enable |
| core_en | output | 1 | Core regulator enable |
| aio_en | output | 1 | Active I/O regulator enable |
| sio_en | output | 1 | Standby I/O regulator enable |
| xo_en | output | 1 | Crystal oscillator enable |
| hfrc_en | output | 1 | High-frequency RC oscillator enable |
| pll_en | output | 1 | PLL enable |
| por_n | output | 1 | Power-on reset to digital domain, active low |
| aio_drop | output | 1 | Command for the 100 mV droop on the active I/O rail |
| txpwr_out | output | 8 | Clamped TX power, signed dBm |
| fault | output | 1 | Sticky stage timeout flag |

## Verification
Two pairs of events can land on the same clock edge. The first is a stage timeout and the arrival of that stage's ready flag. The bench holds aon_rdy low and raises it just before the edge on which the timeout count expires. It then expects the low-frequency clocks to start with fault still clear, and it contrasts this with a second run that leaves aon_rdy low one edge longer and expects fault. The second pair is brown-out loss and a sleep request. The bench drops bor_ok and raises sleep_req in the same cycle, then expects the full reset state with sio_en low. Expected edge counts for each stage are derived from the small DGL_CYC, STB_CYC and TO_CYC values the bench sets.

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int DGL_CYC = 320,
  parameter int STB_CYC = 256,
  parameter int TO_CYC  = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bor_ok,
  input  logic              aon_rdy,
  input  logic              ret_rdy,
  input  logic              lfrc_rdy,
  input  logic              rng_rdy,
  input  logic              buck_rdy,
  input  logic              rfldo_rdy,
  input  logic              core_rdy,
  input  logic              aio_rdy,
  input  logic              xo_rdy,
  input  logic              hfrc_rdy,
  input  logic              pll_rdy,
  input  logic              sleep_req,
  input  logic              rf_src_ldo,
  input  logic signed [7:0] txpwr_req,
  output logic              aon_en,
  output logic              ret_en,
  output logic              lfrc_en,
  output logic              rng_en,
  output logic              buck_en,
  output logic              rfldo_en,
  output logic              core_en,
  output logic              aio_en,
  output logic              sio_en,
  output logic              xo_en,
  output logic              hfrc_en,
  output logic              pll_en,
  output logic              por_n,
  output logic              aio_drop,
  output logic signed [7:0] txpwr_out,
  output logic              fault
);
  localparam int MAXC = (DGL_CYC > STB_CYC) ? ((DGL_CYC > TO_CYC) ? DGL_CYC : TO_CYC)
                                            : ((STB_CYC > TO_CYC) ? STB_CYC : TO_CYC);
  localparam int CW = $clog2(MAXC + 1) + 1;
  localparam logic [CW-1:0] CSAT = '1;
  localparam logic signed [7:0] PWR_MIN = -8'sd20;
  localparam logic signed [7:0] PWR_MAX_SW = 8'sd6;
  localparam logic signed [7:0] PWR_MAX_LDO = 8'sd15;

  typedef enum logic [3:0] {
    S_OFF, S_DGL, S_AONW, S_LFC, S_SUP, S_STB, S_MAIN, S_RUN, S_SLP
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt;
  logic is_wait, wait_ok, tmo;

  always_comb begin
    nxt = st;
    is_wait = 1'b0;
    wait_ok = 1'b0;
    case (st)
      S_OFF:  nxt = S_DGL;
      S_DGL:  if (cnt == CW'(DGL_CYC - 1)) nxt = S_AONW;
      S_AONW: begin is_wait = 1'b1; wait_ok = aon_rdy && ret_rdy; end
      S_LFC:  begin is_wait = 1'b1; wait_ok = lfrc_rdy && rng_rdy; end
      S_SUP:  begin is_wait = 1'b1; wait_ok = buck_rdy && rfldo_rdy; end
      S_STB:  if (cnt == CW'(STB_CYC - 1)) nxt = S_MAIN;
      S_MAIN: begin
        is_wait = 1'b1;
        wait_ok = core_rdy && aio_rdy && xo_rdy && hfrc_rdy && pll_rdy;
      end
      S_RUN:  if (sleep_req) nxt = S_SLP;
      S_SLP:  if (!sleep_req) nxt = S_RUN;
      default: nxt = S_OFF;
    endcase
    if (is_wait && wait_ok) nxt = st_t'(st + 4'd1);
  end

  assign tmo = is_wait && !wait_ok && (cnt == CW'(TO_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OFF;
      cnt <= '0;
      fault <= 1'b0;
    end else begin
      if (!bor_ok) begin
        st <= S_OFF;
        cnt <= '0;
      end else begin
        if (tmo) fault <= 1'b1;
        if (nxt != st) begin
          st <= nxt;
          cnt <= '0;
        end else if (cnt != CSAT) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign aon_en   = 1'b1;
  assign ret_en   = 1'b1;
  assign lfrc_en  = st >= S_LFC;
  assign rng_en   = st >= S_LFC;
  assign buck_en  = st >= S_SUP;
  assign rfldo_en = st >= S_SUP;
  assign core_en  = st >= S_MAIN;
  assign xo_en    = st >= S_MAIN;
  assign hfrc_en  = st >= S_MAIN;
  assign aio_en   = (st == S_MAIN) || (st == S_RUN);
  assign sio_en   = st == S_SLP;
  assign pll_en   = (st >= S_MAIN) && xo_rdy;
  assign por_n    = st >= S_RUN;
  assign aio_drop = st == S_RUN;

  logic signed [7:0] pwr_max;
  assign pwr_max   = rf_src_ldo ? PWR_MAX_LDO : PWR_MAX_SW;
  assign txpwr_out = (txpwr_req < PWR_MIN) ? PWR_MIN :
                     (txpwr_req > pwr_max) ? pwr_max : txpwr_req;

  p_lf_after_aon_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lfrc_en) |-> $past(aon_rdy && ret_rdy));
  p_por_all_rdy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_n) |-> $past(core_rdy && aio_rdy && xo_rdy && hfrc_rdy && pll_rdy));
  p_io_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sio_en && aio_en));
  p_tx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (txpwr_out >= PWR_MIN) && (txpwr_out <= (rf_src_ldo ? PWR_MAX_LDO : PWR_MAX_SW)));
  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
  p_bor_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bor_ok |=> (!por_n && !lfrc_en && !buck_en && !core_en && !sio_en && aon_en && ret_en));
endmodule

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb_top;
  localparam int CLK_PER = 10;
  localparam int DGL = 4;
  localparam int STB = 3;
  localparam int TO  = 6;

  logic clk = 1'b0, rst_n = 1'b0, bor_ok = 1'b0;
  logic aon_rdy = 0, ret_rdy = 0, lfrc_rdy = 0, rng_rdy = 0, buck_rdy = 0, rfldo_rdy = 0;
  logic core_rdy = 0, aio_rdy = 0, xo_rdy = 0, hfrc_rdy = 0, pll_rdy = 0;
  logic sleep_req = 0, rf_src_ldo = 0;
  logic signed [7:0] txpwr_req = '0;
  logic aon_en, ret_en, lfrc_en, rng_en, buck_en, rfldo_en, core_en, aio_en, sio_en;
  logic xo_en, hfrc_en, pll_en, por_n, aio_drop, fault;
  logic signed [7:0] txpwr_out;
  int errs = 0, checks = 0;

  always #(CLK_PER/2) clk = ~clk;

  pwr_seq_ctrl #(.DGL_CYC(DGL), .STB_CYC(STB), .TO_CYC(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .bor_ok(bor_ok), .aon_rdy(aon_rdy), .ret_rdy(ret_rdy),
    .lfrc_rdy(lfrc_rdy), .rng_rdy(rng_rdy), .buck_rdy(buck_rdy), .rfldo_rdy(rfldo_rdy),
    .core_rdy(core_rdy), .aio_rdy(aio_rdy), .xo_rdy(xo_rdy), .hfrc_rdy(hfrc_rdy),
    .pll_rdy(pll_rdy), .sleep_req(sleep_req), .rf_src_ldo(rf_src_ldo), .txpwr_req(txpwr_req),
    .aon_en(aon_en), .ret_en(ret_en), .lfrc_en(lfrc_en), .rng_en(rng_en), .buck_en(buck_en),
    .rfldo_en(rfldo_en), .core_en(core_en), .aio_en(aio_en), .sio_en(sio_en), .xo_en(xo_en),
    .hfrc_en(hfrc_en), .pll_en(pll_en), .por_n(por_n), .aio_drop(aio_drop),
    .txpwr_out(txpwr_out), .fault(fault));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic all_rdy(input logic v);
    aon_rdy = v; ret_rdy = v; lfrc_rdy = v; rng_rdy = v; buck_rdy = v; rfldo_rdy = v;
    core_rdy = v; aio_rdy = v; xo_rdy = v; hfrc_rdy = v; pll_rdy = v;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bor_ok = 1'b0; sleep_req = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  initial begin
    #(CLK_PER * 150000);
    errs++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int t_lf, t_sup, t_main, t_por, pll_at_main, main_grp;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 aon/ret", {aon_en, ret_en}, 3);
    chk("R1 others", {lfrc_en, rng_en, buck_en, rfldo_en, core_en, aio_en, sio_en, xo_en, hfrc_en, pll_en}, 0);
    chk("R1 por_n", por_n, 0);
    chk("R1 fault", fault, 0);

    // Normal bring-up: R2 R3 R4 R6
    all_rdy(1'b1);
    bor_ok = 1'b1;
    t_lf = 0; t_sup = 0; t_main = 0; t_por = 0; pll_at_main = 0; main_grp = 0;
    for (int i = 1; i <= 40; i++) begin
      step(1);
      if (lfrc_en && rng_en && t_lf == 0) t_lf = i;
      if (buck_en && rfldo_en && t_sup == 0) t_sup = i;
      if (core_en && t_main == 0) begin
        t_main = i;
        main_grp = {aio_en, xo_en, hfrc_en};
        pll_at_main = pll_en;
      end
      if (por_n && t_por == 0) t_por = i;
    end
    chk("R2 lf start edge", t_lf, DGL + 2);
    chk("R3 supply start edge", t_sup, DGL + 3);
    chk("R4 main start edge", t_main, DGL + 4 + STB);
    chk("R4 main group together", main_grp, 7);
    chk("R5 pll with xo stable", pll_at_main, 1);
    chk("R6 por release edge", t_por, DGL + 5 + STB);
    chk("R6 aio_drop while running", aio_drop, 1);
    chk("R9 no fault normal", fault, 0);

    // R7 sleep swap and wake
    sleep_req = 1'b1;
    step(1);
    chk("R7 sleep sio_en", sio_en, 1);
    chk("R7 sleep aio_en", aio_en, 0);
    chk("R7 sleep aio_drop", aio_drop, 0);
    chk("R7 sleep por_n", por_n, 1);
    sleep_req = 1'b0;
    step(1);
    chk("R7 wake aio_en/sio_en/drop", {aio_en, sio_en, aio_drop}, 5);

    // R10 brown-out and sleep in same cycle
    bor_ok = 1'b0; sleep_req = 1'b1;
    step(1);
    chk("R10 por_n", por_n, 0);
    chk("R10 enables", {lfrc_en, buck_en, core_en, aio_en, sio_en, pll_en}, 0);
    chk("R10 aon/ret stay", {aon_en, ret_en}, 3);
    sleep_req = 1'b0;

    // R5 pll held off until crystal stable; R2 gating on aon/ret
    xo_rdy = 1'b0;
    aon_rdy = 1'b0;
    bor_ok = 1'b1;
    step(DGL + 3);
    chk("R2 lf held while aon not ready", lfrc_en, 0);
    aon_rdy = 1'b1;
    step(1);
    chk("R2 lf after aon ready", lfrc_en, 1);
    step(2 + STB);
    chk("R4 in main stage", core_en, 1);
    chk("R5 pll held", pll_en, 0);
    chk("R6 por held without xo", por_n, 0);
    xo_rdy = 1'b1;
    #1;
    chk("R5 pll follows xo", pll_en, 1);
    step(1);
    chk("R6 por after xo", por_n, 1);

    // R9 timeout with ready arriving on the final edge: no fault
    do_reset();
    all_rdy(1'b1);
    aon_rdy = 1'b0;
    bor_ok = 1'b1;
    step(DGL + TO);
    aon_rdy = 1'b1;
    step(1);
    chk("R9 ready on last edge advances", lfrc_en, 1);
    chk("R9 ready on last edge no fault", fault, 0);

    // R9 timeout fires, sticky across brown-out, cleared by rst_n
    do_reset();
    all_rdy(1'b1);
    aon_rdy = 1'b0;
    bor_ok = 1'b1;
    step(DGL + TO);
    chk("R9 no fault before limit", fault, 0);
    step(1);
    chk("R9 fault at limit", fault, 1);
    aon_rdy = 1'b1;
    step(1);
    chk("R9 late ready still advances", lfrc_en, 1);
    bor_ok = 1'b0;
    step(2);
    chk("R9 fault sticky over brown-out", fault, 1);
    do_reset();
    chk("R9 fault cleared by reset", fault, 0);

    // R8 TX power clamp sweep
    for (int m = 0; m < 2; m++) begin
      for (int p = -40; p <= 40; p++) begin
        int hi, exp_p;
        rf_src_ldo = m[0];
        txpwr_req = 8'(p);
        hi = (m == 1) ? 15 : 6;
        exp_p = (p < -20) ? -20 : ((p > hi) ? hi : p);
        #1;
        chk("R8 tx clamp", int'(txpwr_out), exp_p);
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule